// File: doc/BRIEF.md
# Write-Through Invalidate Data Cache Controller

This block is the data-side cache controller of one processor node in a multicore system. Coherence is kept by a home directory, and the cache never holds modified data. The cache is direct-mapped. Its default geometry is 128 lines of eight 32-bit words, which is 4 KB with 32-byte lines. A load that hits returns its word on the cycle after it is accepted. A load that misses stalls the processor while the whole line is fetched from home memory over the network port.

Every store, whether it hits or misses, is posted as a single-word write into a small write buffer. The buffer drains to memory in order. A store that hits also updates the local copy of the word. A store that misses allocates nothing. The processor stalls on a store only while the write buffer is full.

The directory can invalidate any line through a separate command port. Each command is acknowledged on the following cycle. If a command names the line that is being filled, the fill data still answers the waiting load, but the line is not installed.

Top module: `wti_dcache`

## Requirements
- R1: After reset, no line is valid, so the first load to any address misses. Also after reset, `cpu_ready_o` is 1, `cpu_rvalid_o` is 0, `net_req_valid_o` is 0 and `inv_ack_o` is 0.
- R2: A load that hits is accepted without stall. `cpu_rvalid_o` is 1 with the word on the cycle after acceptance, and no network request is made.
- R3: For a load miss, exactly one read request is issued (`net_req_write_o` = 0), and its address is line-aligned (offset bits zero). The cache then takes WPL response beats, which carry words 0 to WPL-1 of the line in order. The requested word is returned on the cycle after the last beat.
- R4: A store that hits updates the cached word, so a later load hit returns the new value. The store is also sent to memory as a write request with its full address and data.
- R5: A store that misses does not allocate, so a following load to that address misses.
- R6: While the write buffer is not full, stores are accepted with no stall. While it is full, `cpu_ready_o` is 0 for a store. Buffered writes leave the network port in the order they were accepted.
- R7: While a load miss waits for its read to be issued, the read request takes the network port ahead of older buffered writes to other lines.
- R8: A load miss issues no read request while the write buffer holds a store to the same line. Once those stores drain, the load returns the stored data.
- R9: `inv_ack_o` is 1 on the cycle after `inv_valid_i`. An invalidate whose tag matches clears the line, so the next load misses. An invalidate for the same index with another tag leaves the line valid.
- R10: An invalidate of the line being filled does not change the data returned to the waiting load, but the line is not installed, so the next load to it misses.
- R11: A fill replaces the line held at the same index with a different tag, so a later load to the old line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request valid |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | AW | Byte address, word aligned |
| cpu_wdata_i | input | DW | Store data |
| cpu_ready_o | output | 1 | Request accepted this cycle when high |
| cpu_rvalid_o | output | 1 | Load data valid |
| cpu_rdata_o | output | DW | Load data |
| net_req_valid_o | output | 1 | Network request valid |
| net_req_ready_i | input | 1 | Network request accepted |
| net_req_write_o | output | 1 | 1 = word write, 0 = line read |
| net_req_addr_o | output | AW | Request address |
| net_req_wdata_o | output | DW | Write data |
| net_rsp_valid_i | input | 1 | Read response beat valid |
| net_rsp_data_i | input | DW | Read response word |
| inv_valid_i | input | 1 | Invalidate command from the directory |
| inv_line_i | input | AW-log2(WPL*DW/8) | Line address to invalidate |
| inv_ack_o | output | 1 | Invalidate acknowledge |

## Verification
The bench builds the cache with AW=16, four lines of eight words and a four-entry write buffer. With only four indices, conflict evictions and same-index invalidates occur with small addresses. With four buffer entries, a full-buffer stall is reached after four held stores. A memory model in the bench can hold back write grants. This lets the bench set up the two ordering cases: a read overtaking writes to other lines, and a read waiting behind a write to its own line. The bench also injects an invalidate in the middle of a fill to check that the line is not installed.

// File: rtl/wti_pkg.sv
package wti_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_REQ,
    ST_FILL
  } miss_state_e;
endpackage

// File: rtl/wti_wbuf.sv
module wti_wbuf #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int OFF_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                push_i,
  input  logic [AW-1:0]       push_addr_i,
  input  logic [DW-1:0]       push_data_i,
  input  logic                pop_i,
  output logic [AW-1:0]       head_addr_o,
  output logic [DW-1:0]       head_data_o,
  output logic                empty_o,
  output logic                full_o,
  input  logic [AW-OFF_W-1:0] match_line_i,
  output logic                line_hit_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] live_q;
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [PW:0]      cnt_q;
  logic [DEPTH-1:0] hit_vec;

  assign empty_o     = (cnt_q == '0);
  assign full_o      = (cnt_q == (PW+1)'(DEPTH));
  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      live_q   <= '0;
    end else begin
      if (push_i) begin
        wr_ptr_q         <= bump(wr_ptr_q);
        live_q[wr_ptr_q] <= 1'b1;
      end
      if (pop_i) begin
        rd_ptr_q         <= bump(rd_ptr_q);
        live_q[rd_ptr_q] <= 1'b0;
      end
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (!push_i && pop_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_ptr_q] <= push_addr_i;
      data_q[wr_ptr_q] <= push_data_i;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign hit_vec[g] = live_q[g] && (addr_q[g][AW-1:OFF_W] == match_line_i);
  end
  assign line_hit_o = |hit_vec;

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/wti_store.sv
module wti_store #(
  parameter int DW    = 32,
  parameter int LINES = 128,
  parameter int WPL   = 8,
  parameter int LA_W  = 25
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [LA_W+$clog2(WPL)-1:0] lk_waddr_i,
  output logic                        hit_o,
  output logic [DW-1:0]               rd_o,
  input  logic                        wr_en_i,
  input  logic [$clog2(LINES)+$clog2(WPL)-1:0] wr_slot_i,
  input  logic [DW-1:0]               wr_data_i,
  input  logic                        drop_en_i,
  input  logic [$clog2(LINES)-1:0]    drop_idx_i,
  input  logic                        inv_en_i,
  input  logic [LA_W-1:0]             inv_line_i,
  input  logic                        fill_en_i,
  input  logic [LA_W-1:0]             fill_line_i
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int WRD_W  = $clog2(WPL);
  localparam int TAG_W  = LA_W - IDX_W;
  localparam int SLOTS  = LINES * WPL;

  logic [TAG_W-1:0] tag_q  [LINES];
  logic [DW-1:0]    data_q [SLOTS];
  logic [LINES-1:0] valid_q;

  logic [LA_W-1:0]  lk_line;
  logic [IDX_W-1:0] lk_idx, inv_idx, fill_idx;
  logic [TAG_W-1:0] lk_tag, inv_tag, fill_tag;

  assign lk_line  = lk_waddr_i[LA_W+WRD_W-1:WRD_W];
  assign lk_idx   = lk_line[IDX_W-1:0];
  assign lk_tag   = lk_line[LA_W-1:IDX_W];
  assign inv_idx  = inv_line_i[IDX_W-1:0];
  assign inv_tag  = inv_line_i[LA_W-1:IDX_W];
  assign fill_idx = fill_line_i[IDX_W-1:0];
  assign fill_tag = fill_line_i[LA_W-1:IDX_W];

  assign hit_o = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign rd_o  = data_q[lk_waddr_i[IDX_W+WRD_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      if (fill_en_i) valid_q[fill_idx] <= 1'b1;
      if (drop_en_i) valid_q[drop_idx_i] <= 1'b0;
      // remote invalidate wins over any same-cycle install
      if (inv_en_i && valid_q[inv_idx] && tag_q[inv_idx] == inv_tag)
        valid_q[inv_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) tag_q[fill_idx] <= fill_tag;
    if (wr_en_i)   data_q[wr_slot_i] <= wr_data_i;
  end

  a_r3_no_fill_on_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_en_i && drop_en_i));
endmodule

// File: rtl/wti_dcache.sv
module wti_dcache #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int LINES    = 128,
  parameter int WPL      = 8,
  parameter int WB_DEPTH = 8,
  localparam int LA_W    = AW - $clog2(DW/8) - $clog2(WPL)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cpu_req_i,
  input  logic            cpu_we_i,
  input  logic [AW-1:0]   cpu_addr_i,
  input  logic [DW-1:0]   cpu_wdata_i,
  output logic            cpu_ready_o,
  output logic            cpu_rvalid_o,
  output logic [DW-1:0]   cpu_rdata_o,
  output logic            net_req_valid_o,
  input  logic            net_req_ready_i,
  output logic            net_req_write_o,
  output logic [AW-1:0]   net_req_addr_o,
  output logic [DW-1:0]   net_req_wdata_o,
  input  logic            net_rsp_valid_i,
  input  logic [DW-1:0]   net_rsp_data_i,
  input  logic            inv_valid_i,
  input  logic [LA_W-1:0] inv_line_i,
  output logic            inv_ack_o
);
  import wti_pkg::*;

  localparam int BYTE_W = $clog2(DW/8);
  localparam int WRD_W  = $clog2(WPL);
  localparam int IDX_W  = $clog2(LINES);
  localparam int OFF_W  = BYTE_W + WRD_W;
  localparam int WA_W   = AW - BYTE_W;
  localparam int SLOT_W = IDX_W + WRD_W;

  miss_state_e       state_q;
  logic [WA_W-1:0]   miss_waddr_q;
  logic [WRD_W-1:0]  beat_q;
  logic              kill_q;
  logic              rvalid_q, ack_q;
  logic [DW-1:0]     rdata_q;

  logic [WA_W-1:0]   cpu_waddr;
  logic [LA_W-1:0]   cpu_line, miss_line;
  logic [WRD_W-1:0]  miss_word;
  logic              hit;
  logic [DW-1:0]     hit_word;
  logic              wb_empty, wb_full, wb_line_hit, wb_pop;
  logic [AW-1:0]     wb_addr;
  logic [DW-1:0]     wb_data;
  logic              idle, load_acc, store_acc, load_miss;
  logic              rsp_beat, fill_last, inv_on_miss, install;
  logic              read_sel;
  logic              st_wr;
  logic [SLOT_W-1:0] wr_slot;
  logic [DW-1:0]     wr_data;

  assign cpu_waddr = cpu_addr_i[AW-1:BYTE_W];
  assign cpu_line  = cpu_addr_i[AW-1:OFF_W];
  assign miss_line = miss_waddr_q[WA_W-1:WRD_W];
  assign miss_word = miss_waddr_q[WRD_W-1:0];

  assign idle      = (state_q == ST_IDLE);
  assign load_acc  = idle && cpu_req_i && !cpu_we_i;
  assign store_acc = idle && cpu_req_i && cpu_we_i && !wb_full;
  assign load_miss = load_acc && !hit;
  assign cpu_ready_o = idle && !(cpu_we_i && wb_full);

  assign rsp_beat  = (state_q == ST_FILL) && net_rsp_valid_i;
  assign fill_last = rsp_beat && (beat_q == WRD_W'(WPL-1));

  // invalidate aimed at the line under fill (or just being missed on)
  assign inv_on_miss = inv_valid_i &&
    ((!idle && inv_line_i == miss_line) || (load_miss && inv_line_i == cpu_line));
  assign install = fill_last && !kill_q && !inv_on_miss;

  assign st_wr   = store_acc && hit;
  assign wr_slot = st_wr ? cpu_waddr[SLOT_W-1:0] : {miss_line[IDX_W-1:0], beat_q};
  assign wr_data = st_wr ? cpu_wdata_i : net_rsp_data_i;

  wti_store #(
    .DW(DW), .LINES(LINES), .WPL(WPL), .LA_W(LA_W)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_waddr_i  (cpu_waddr),
    .hit_o       (hit),
    .rd_o        (hit_word),
    .wr_en_i     (st_wr || rsp_beat),
    .wr_slot_i   (wr_slot),
    .wr_data_i   (wr_data),
    .drop_en_i   (load_miss),
    .drop_idx_i  (cpu_line[IDX_W-1:0]),
    .inv_en_i    (inv_valid_i),
    .inv_line_i  (inv_line_i),
    .fill_en_i   (install),
    .fill_line_i (miss_line)
  );

  wti_wbuf #(
    .AW(AW), .DW(DW), .DEPTH(WB_DEPTH), .OFF_W(OFF_W)
  ) u_wbuf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (store_acc),
    .push_addr_i  (cpu_addr_i),
    .push_data_i  (cpu_wdata_i),
    .pop_i        (wb_pop),
    .head_addr_o  (wb_addr),
    .head_data_o  (wb_data),
    .empty_o      (wb_empty),
    .full_o       (wb_full),
    .match_line_i (miss_line),
    .line_hit_o   (wb_line_hit)
  );

  // a pending line read owns the port; otherwise the buffer drains
  assign read_sel        = (state_q == ST_REQ);
  assign net_req_valid_o = read_sel || !wb_empty;
  assign net_req_write_o = !read_sel;
  assign net_req_addr_o  = read_sel ? {miss_line, {OFF_W{1'b0}}} : wb_addr;
  assign net_req_wdata_o = wb_data;
  assign wb_pop          = !read_sel && !wb_empty && net_req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      miss_waddr_q <= '0;
      beat_q       <= '0;
      kill_q       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (load_miss) begin
          state_q      <= ST_HOLD;
          miss_waddr_q <= cpu_waddr;
        end
        ST_HOLD: if (!wb_line_hit) state_q <= ST_REQ;
        ST_REQ: if (net_req_ready_i) begin
          state_q <= ST_FILL;
          beat_q  <= '0;
        end
        ST_FILL: if (net_rsp_valid_i) begin
          beat_q <= beat_q + 1'b1;
          if (fill_last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (load_miss)       kill_q <= inv_on_miss;
      else if (fill_last)  kill_q <= 1'b0;
      else if (!idle)      kill_q <= kill_q || inv_on_miss;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      ack_q    <= 1'b0;
    end else begin
      rvalid_q <= (load_acc && hit) || fill_last;
      ack_q    <= inv_valid_i;
      if (load_acc && hit)                    rdata_q <= hit_word;
      else if (rsp_beat && beat_q == miss_word) rdata_q <= net_rsp_data_i;
    end
  end

  assign cpu_rvalid_o = rvalid_q;
  assign cpu_rdata_o  = rdata_q;
  assign inv_ack_o    = ack_q;

  a_r8_raw_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (net_req_valid_o && !net_req_write_o) |-> !wb_line_hit);
  a_r3_line_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (net_req_valid_o && !net_req_write_o) |-> (net_req_addr_o[OFF_W-1:0] == '0));
  a_r9_ack_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_i |=> inv_ack_o);
  a_r6_full_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_we_i && wb_full) |-> !cpu_ready_o);
  a_r3_no_rsp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_FILL) |-> !install);
endmodule

// File: tb/wti_dcache_tb_top.sv
module wti_dcache_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LINES = 4;
  localparam int WPL = 8;
  localparam int WB_DEPTH = 4;
  localparam int LA_W = AW - 2 - 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            cpu_req = 0, cpu_we = 0;
  logic [AW-1:0]   cpu_addr = '0;
  logic [DW-1:0]   cpu_wdata = '0;
  logic            cpu_ready, cpu_rvalid;
  logic [DW-1:0]   cpu_rdata;
  logic            nq_valid, nq_ready = 1'b1, nq_write;
  logic [AW-1:0]   nq_addr;
  logic [DW-1:0]   nq_wdata;
  logic            ns_valid = 1'b0;
  logic [DW-1:0]   ns_data = '0;
  logic            inv_valid = 1'b0;
  logic [LA_W-1:0] inv_line = '0;
  logic            inv_ack;

  wti_dcache #(.AW(AW), .DW(DW), .LINES(LINES), .WPL(WPL), .WB_DEPTH(WB_DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready), .cpu_rvalid_o(cpu_rvalid), .cpu_rdata_o(cpu_rdata),
    .net_req_valid_o(nq_valid), .net_req_ready_i(nq_ready), .net_req_write_o(nq_write),
    .net_req_addr_o(nq_addr), .net_req_wdata_o(nq_wdata),
    .net_rsp_valid_i(ns_valid), .net_rsp_data_i(ns_data),
    .inv_valid_i(inv_valid), .inv_line_i(inv_line), .inv_ack_o(inv_ack)
  );

  int n_checks = 0, n_fail = 0;
  logic [DW-1:0] mem [1024];
  logic [AW-1:0] wr_log_a [64];
  logic [DW-1:0] wr_log_d [64];
  int wr_n = 0, rd_n = 0;
  logic [AW-1:0] rd_last = '0;
  bit hold_wr = 0;
  int rsp_left = 0, rsp_dly = 0, rsp_beat = 0;
  logic [AW-1:0] rsp_base = '0;

  function automatic logic [DW-1:0] init_word(input int i);
    return 32'hC0DE0000 | i;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // home memory model: grants, writes, line responses
  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = init_word(i);
    forever begin
      @(negedge clk);
      if (rsp_left > 0 && rsp_dly == 0) begin
        ns_valid = 1'b1;
        ns_data  = mem[(rsp_base >> 2) + rsp_beat];
        rsp_beat++;
        rsp_left--;
      end else begin
        ns_valid = 1'b0;
        if (rsp_dly > 0) rsp_dly--;
      end
      nq_ready = !(hold_wr && nq_write);
      if (rst_n && nq_valid && nq_ready) begin
        if (nq_write) begin
          mem[nq_addr >> 2] = nq_wdata;
          if (wr_n < 64) begin
            wr_log_a[wr_n] = nq_addr;
            wr_log_d[wr_n] = nq_wdata;
          end
          wr_n++;
        end else begin
          rd_n++;
          rd_last  = nq_addr;
          rsp_base = nq_addr;
          rsp_left = WPL;
          rsp_beat = 0;
          rsp_dly  = 2;
        end
      end
    end
  end

  task automatic cpu_load(input logic [AW-1:0] a, output logic [DW-1:0] d, output int cyc);
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = a; cyc = 0;
    forever begin
      #1;
      if (cpu_ready) break;
      @(negedge clk); cyc++;
    end
    @(negedge clk);
    cpu_req = 0;
    while (!cpu_rvalid) begin @(negedge clk); cyc++; end
    d = cpu_rdata;
  endtask

  task automatic cpu_store(input logic [AW-1:0] a, input logic [DW-1:0] d, output int cyc);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d; cyc = 0;
    forever begin
      #1;
      if (cpu_ready) break;
      @(negedge clk); cyc++;
    end
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic send_inv(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    inv_valid = 1; inv_line = a[AW-1:5];
    @(negedge clk);
    inv_valid = 0;
    check(inv_ack == 1'b1, req, "inv ack", 32'(inv_ack), 1);
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(cpu_ready == 1'b1, "R1", "ready", 32'(cpu_ready), 1);
    check(cpu_rvalid == 1'b0, "R1", "rvalid", 32'(cpu_rvalid), 0);
    check(nq_valid == 1'b0, "R1", "net req", 32'(nq_valid), 0);
    check(inv_ack == 1'b0, "R1", "ack", 32'(inv_ack), 0);
  endtask

  task automatic t_miss_then_hit();
    logic [DW-1:0] d; int c, r0;
    r0 = rd_n;
    cpu_load(16'h0104, d, c);
    check(rd_n == r0 + 1, "R1", "cold load misses", 32'(rd_n), 32'(r0 + 1));
    check(rd_last == 16'h0100, "R3", "read aligned", 32'(rd_last), 32'h0100);
    check(d == init_word(16'h41), "R3", "miss data", d, init_word(16'h41));
    check(c > WPL, "R3", "miss stalls", 32'(c), WPL + 1);
    cpu_load(16'h0108, d, c);
    check(d == init_word(16'h42), "R2", "hit data", d, init_word(16'h42));
    check(c == 0, "R2", "hit latency", 32'(c), 0);
    check(rd_n == r0 + 1, "R2", "no read on hit", 32'(rd_n), 32'(r0 + 1));
  endtask

  task automatic t_store_hit();
    logic [DW-1:0] d; int c, r0;
    r0 = rd_n;
    cpu_store(16'h0108, 32'h1111_2222, c);
    check(c == 0, "R6", "store no stall", 32'(c), 0);
    cpu_load(16'h0108, d, c);
    check(d == 32'h1111_2222, "R4", "updated word", d, 32'h1111_2222);
    check(c == 0 && rd_n == r0, "R4", "still hit", 32'(rd_n), 32'(r0));
    settle();
    check(wr_log_a[wr_n-1] == 16'h0108, "R4", "write addr", 32'(wr_log_a[wr_n-1]), 32'h0108);
    check(wr_log_d[wr_n-1] == 32'h1111_2222, "R4", "write data", wr_log_d[wr_n-1], 32'h1111_2222);
  endtask

  task automatic t_store_miss();
    logic [DW-1:0] d; int c, r0;
    cpu_store(16'h0244, 32'h3333_4444, c);
    settle();
    r0 = rd_n;
    cpu_load(16'h0244, d, c);
    check(rd_n == r0 + 1, "R5", "no allocate", 32'(rd_n), 32'(r0 + 1));
    check(d == 32'h3333_4444, "R5", "memory data", d, 32'h3333_4444);
  endtask

  task automatic t_conflict();
    logic [DW-1:0] d; int c, r0;
    r0 = rd_n;
    cpu_load(16'h0300, d, c);
    check(d == init_word(16'hC0), "R11", "new line data", d, init_word(16'hC0));
    cpu_load(16'h0104, d, c);
    check(rd_n == r0 + 2, "R11", "old line evicted", 32'(rd_n), 32'(r0 + 2));
  endtask

  task automatic t_inv();
    logic [DW-1:0] d; int c, r0;
    r0 = rd_n;
    send_inv(16'h0500, "R9");
    cpu_load(16'h0104, d, c);
    check(rd_n == r0 && c == 0, "R9", "other tag kept", 32'(rd_n), 32'(r0));
    send_inv(16'h0100, "R9");
    cpu_load(16'h0104, d, c);
    check(rd_n == r0 + 1, "R9", "matching line cleared", 32'(rd_n), 32'(r0 + 1));
  endtask

  task automatic t_fill_kill();
    logic [DW-1:0] d; int c, r0;
    r0 = rd_n;
    fork
      cpu_load(16'h0060, d, c);
      begin
        while (rd_n == r0) @(negedge clk);
        repeat (3) @(negedge clk);
        inv_valid = 1; inv_line = 16'h0060 >> 5;
        @(negedge clk);
        inv_valid = 0;
      end
    join
    check(d == init_word(16'h18), "R10", "fill data returned", d, init_word(16'h18));
    cpu_load(16'h0060, d, c);
    check(rd_n == r0 + 2, "R10", "line not installed", 32'(rd_n), 32'(r0 + 2));
  endtask

  task automatic t_read_first();
    logic [DW-1:0] d; int c, r0, w0;
    hold_wr = 1;
    w0 = wr_n; r0 = rd_n;
    cpu_store(16'h0400, 32'h5555_6666, c);
    cpu_load(16'h0084, d, c);
    check(rd_n == r0 + 1 && wr_n == w0, "R7", "read passes write", 32'(wr_n), 32'(w0));
    check(d == init_word(16'h21), "R7", "load data", d, init_word(16'h21));
    hold_wr = 0;
    settle();
    check(mem[16'h100] == 32'h5555_6666, "R7", "write drained", mem[16'h100], 32'h5555_6666);
  endtask

  task automatic t_raw();
    logic [DW-1:0] d; int c, r0;
    hold_wr = 1;
    cpu_store(16'h00C8, 32'h7777_8888, c);
    r0 = rd_n;
    fork
      cpu_load(16'h00C8, d, c);
      begin
        repeat (6) @(negedge clk);
        check(rd_n == r0, "R8", "read held", 32'(rd_n), 32'(r0));
        hold_wr = 0;
      end
    join
    check(d == 32'h7777_8888, "R8", "reads stored value", d, 32'h7777_8888);
  endtask

  task automatic t_full();
    int c, w0, stall;
    hold_wr = 1;
    w0 = wr_n;
    for (int i = 0; i < WB_DEPTH; i++) begin
      cpu_store(16'h0200 + 16'(4 * i), 32'hA000_0000 + i, c);
      check(c == 0, "R6", "no stall below full", 32'(c), 0);
    end
    fork
      cpu_store(16'h0200 + 16'(4 * WB_DEPTH), 32'hA000_0000 + WB_DEPTH, stall);
      begin
        repeat (5) @(negedge clk);
        hold_wr = 0;
      end
    join
    check(stall >= 5, "R6", "stall when full", 32'(stall), 5);
    settle();
    for (int i = 0; i <= WB_DEPTH; i++)
      check(wr_log_a[w0 + i] == 16'h0200 + 16'(4 * i), "R6", "write order",
            32'(wr_log_a[w0 + i]), 32'(16'h0200 + 4 * i));
  endtask

  bit done = 0;
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_miss_then_hit();
    t_store_hit();
    t_store_miss();
    t_conflict();
    t_inv();
    t_fill_kill();
    t_read_first();
    t_raw();
    t_full();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule